// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a parameterised register (eight stages by default) that can hold its contents, move them one place in either direction, or take a full word from a parallel bus. The mode is chosen on each rising clock edge by a two-bit select. The parallel pins are shared between load data and register readout. For synthesis they are split into three signals: `bus_in` carries data into the register, `bus_out` carries the register contents, and `bus_oe` says when a pad should drive `bus_out` onto the wire.

The bus drivers are gated by two active-low enables. A parallel load turns the drivers off no matter what the enables say, because during a load the pins act as inputs. The two end stages also feed dedicated serial outputs, which are never gated. This lets several of these registers be chained. An active-low clear empties the register at once, without waiting for a clock edge.

Stage 0 is the low end of the word (the "A" end) and stage W-1 is the high end (the "H" end).

Top module: `usr_bus_shifter`

## Requirements
- R1: With mode 2'b00 (hold), a rising edge leaves all stages unchanged.
- R2: With mode 2'b01 (shift toward the high end), a rising edge loads stage 0 from `ser_right_in` and loads stage i from the old stage i-1.
- R3: With mode 2'b10 (shift toward the low end), a rising edge loads stage W-1 from `ser_left_in` and loads stage i from the old stage i+1.
- R4: With mode 2'b11 (parallel load), a rising edge copies `bus_in` into all stages.
- R5: When `oe1_n` or `oe2_n` is high, `bus_oe` is low. Hold, shift and load still update the register as in R1 to R4.
- R6: While the mode is 2'b11, `bus_oe` is low whatever the enables are.
- R7: `bus_oe` is high when both enables are low and the mode is not 2'b11. It follows these inputs with no clock delay.
- R8: While `clr_n` is low, every stage reads zero. This takes effect at once, with no clock edge, and overrides every mode, including at clock edges that occur during the clear.
- R9: After `clr_n` rises, the register stays at zero until the next rising edge. That edge applies the mode selected at that time.
- R10: `ser_a_out` always equals stage 0 and `ser_h_out` always equals stage W-1. This holds in every mode, whatever the enables are, and during clear.
- R11: `bus_out` always carries the register contents, whether or not `bus_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift toward high end, 10 shift toward low end, 11 load |
| ser_right_in | input | 1 | Serial input entering stage 0 |
| ser_left_in | input | 1 | Serial input entering stage W-1 |
| oe1_n | input | 1 | Bus driver enable, active low |
| oe2_n | input | 1 | Bus driver enable, active low |
| bus_in | input | W | Word sampled from the shared pins during a load |
| bus_out | output | W | Register contents for the shared pins |
| bus_oe | output | 1 | Drive enable for the shared pins |
| ser_a_out | output | 1 | Stage 0, always driven |
| ser_h_out | output | 1 | Stage W-1, always driven |

## Verification
The bench asserts clear between clock edges and holds it across an edge while a load of all ones is requested. A design with a synchronous clear, or with a clear that yields to the load, would show a non-zero word at one of those checks.

After clear is released, the first edge runs a shift of a single one. This exposes a design that either skips that edge or lets stale state through.

Random runs mix every mode with every combination of the enables. A design that reversed the shift directions, or that drove the bus during a load, would disagree with the bench's own per-stage model.

Because the enables are randomised while the register keeps running, a design that froze the register whenever the drivers were off would also be caught.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } mode_t;
endpackage

// File: rtl/usr_next.sv
module usr_next #(
  parameter int W = 8
) (
  input  logic [W-1:0]       cur,
  input  usr_pkg::mode_t     mode,
  input  logic               up_in,
  input  logic               down_in,
  input  logic [W-1:0]       par_in,
  output logic [W-1:0]       nxt
);
  // Move every bit one place toward the high end; up_in enters at stage 0.
  function automatic logic [W-1:0] f_up(input logic [W-1:0] v, input logic s);
    return {v[W-2:0], s};
  endfunction

  // Move every bit one place toward the low end; s enters at stage W-1.
  function automatic logic [W-1:0] f_down(input logic [W-1:0] v, input logic s);
    return {s, v[W-1:1]};
  endfunction

  always_comb begin
    unique case (mode)
      usr_pkg::MODE_UP:   nxt = f_up(cur, up_in);
      usr_pkg::MODE_DOWN: nxt = f_down(cur, down_in);
      usr_pkg::MODE_LOAD: nxt = par_in;
      default:            nxt = cur;
    endcase
  end
endmodule

// File: rtl/usr_store.sv
module usr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/usr_drive.sv
module usr_drive (
  input  logic           oe1_n,
  input  logic           oe2_n,
  input  usr_pkg::mode_t mode,
  output logic           drive
);
  logic enables_on;
  logic loading;
  assign enables_on = ~(oe1_n | oe2_n);
  assign loading    = (mode == usr_pkg::MODE_LOAD);
  assign drive      = enables_on & ~loading;
endmodule

// File: rtl/usr_bus_shifter.sv
module usr_bus_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         ser_right_in,
  input  logic         ser_left_in,
  input  logic         oe1_n,
  input  logic         oe2_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic         ser_a_out,
  output logic         ser_h_out
);
  localparam int TOP = W - 1;

  usr_pkg::mode_t mode_e;
  logic [W-1:0]   stage_q;
  logic [W-1:0]   stage_d;

  assign mode_e = usr_pkg::mode_t'(mode);

  usr_next #(.W(W)) u_next (
    .cur     (stage_q),
    .mode    (mode_e),
    .up_in   (ser_right_in),
    .down_in (ser_left_in),
    .par_in  (bus_in),
    .nxt     (stage_d)
  );

  usr_store #(.W(W)) u_store (
    .clk   (clk),
    .clr_n (clr_n),
    .d     (stage_d),
    .q     (stage_q)
  );

  usr_drive u_drive (
    .oe1_n (oe1_n),
    .oe2_n (oe2_n),
    .mode  (mode_e),
    .drive (bus_oe)
  );

  assign bus_out   = stage_q;
  assign ser_a_out = stage_q[0];
  assign ser_h_out = stage_q[TOP];
endmodule

// File: rtl/usr_bus_shifter_chk.sv
module usr_bus_shifter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         clr_n,
  input logic [1:0]   mode,
  input logic         ser_right_in,
  input logic         ser_left_in,
  input logic         oe1_n,
  input logic         oe2_n,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] bus_out,
  input logic         bus_oe,
  input logic         ser_a_out,
  input logic         ser_h_out
);
  AST_CLEAR_ZERO: assert property (@(posedge clk) !clr_n |-> (bus_out == '0)); // R8
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b00) |=> $stable(bus_out)); // R1
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b01) |=> (bus_out == {$past(bus_out[W-2:0]), $past(ser_right_in)})); // R2
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b10) |=> (bus_out == {$past(ser_left_in), $past(bus_out[W-1:1])})); // R3
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b11) |=> (bus_out == $past(bus_in))); // R4
  AST_LOAD_NO_DRIVE: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b11) |-> !bus_oe); // R6
  AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!clr_n)
    (oe1_n || oe2_n) |-> !bus_oe); // R5
  AST_SERIAL_ENDS: assert property (@(posedge clk)
    (ser_a_out == bus_out[0]) && (ser_h_out == bus_out[W-1])); // R10
endmodule

bind usr_bus_shifter usr_bus_shifter_chk #(.W(W)) u_chk (
  .clk(clk), .clr_n(clr_n), .mode(mode), .ser_right_in(ser_right_in),
  .ser_left_in(ser_left_in), .oe1_n(oe1_n), .oe2_n(oe2_n), .bus_in(bus_in),
  .bus_out(bus_out), .bus_oe(bus_oe), .ser_a_out(ser_a_out), .ser_h_out(ser_h_out)
);

// File: tb/sim_usr_bus_shifter.sv
module sim_usr_bus_shifter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n;
  logic [1:0]   mode;
  logic         ser_right_in, ser_left_in, oe1_n, oe2_n;
  logic [W-1:0] bus_in;
  logic [W-1:0] bus_out;
  logic         bus_oe, ser_a_out, ser_h_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] model;

  always #10 clk = ~clk;

  usr_bus_shifter #(.W(W)) u0 (
    .clk(clk), .clr_n(clr_n), .mode(mode), .ser_right_in(ser_right_in),
    .ser_left_in(ser_left_in), .oe1_n(oe1_n), .oe2_n(oe2_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .ser_a_out(ser_a_out), .ser_h_out(ser_h_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-stage reference: each stage picks its source by mode.
  function automatic logic [W-1:0] ref_next(input logic [W-1:0] q, input logic [1:0] m,
                                            input logic r, input logic l, input logic [W-1:0] p);
    logic [W-1:0] n;
    for (int i = 0; i < W; i++) begin
      case (m)
        2'd0: n[i] = q[i];
        2'd1: n[i] = (i == 0) ? r : q[i-1];
        2'd2: n[i] = (i == W-1) ? l : q[i+1];
        default: n[i] = p[i];
      endcase
    end
    return n;
  endfunction

  function automatic logic ref_oe(input logic a, input logic b, input logic [1:0] m);
    if (m == 2'd3) return 1'b0;
    if (a == 1'b1 || b == 1'b1) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check_outputs(input string req);
    chk(req, bus_out, model);
    chk("R11", bus_out, model);
    chk("R10", {ser_h_out, ser_a_out}, {model[W-1], model[0]});
  endtask

  task automatic step(input logic [1:0] m, input logic r, input logic l,
                      input logic [W-1:0] p, input logic a, input logic b);
    @(negedge clk);
    mode = m; ser_right_in = r; ser_left_in = l; bus_in = p; oe1_n = a; oe2_n = b;
    #1;
    if (m == 2'd3)         chk("R6", bus_oe, 1'b0);
    else if (a || b)       chk("R5", bus_oe, 1'b0);
    else                   chk("R7", bus_oe, 1'b1);
    @(posedge clk);
    #1;
    model = ref_next(model, m, r, l, p);
    check_outputs((a || b) ? "R5" : tag_of(m));
  endtask

  task automatic mid_clear();
    @(negedge clk);
    #3 clr_n = 1'b0;
    #1;
    model = '0;
    chk("R8", bus_out, '0);
    chk("R10", {ser_h_out, ser_a_out}, 2'b00);
    mode = 2'd3; bus_in = '1;
    @(posedge clk);
    #1 chk("R8", bus_out, '0);
    @(negedge clk);
    clr_n = 1'b1;
    mode = 2'd1; ser_right_in = 1'b1;
    #1 chk("R9", bus_out, '0);
    @(posedge clk);
    #1;
    model = ref_next(model, 2'd1, 1'b1, 1'b0, bus_in);
    chk("R9", bus_out, {{(W-1){1'b0}}, 1'b1});
  endtask

  initial begin : watchdog
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    clr_n = 1'b0; mode = 2'd0; ser_right_in = 1'b0; ser_left_in = 1'b0;
    oe1_n = 1'b0; oe2_n = 1'b0; bus_in = '0; model = '0;
    repeat (2) @(posedge clk);
    #1 chk("R8", bus_out, '0);
    chk("R10", {ser_h_out, ser_a_out}, 2'b00);
    @(negedge clk) clr_n = 1'b1;

    // Directed: load, hold, walk in each direction, enables off.
    step(2'd3, 0, 0, 8'hA5, 1, 1);
    step(2'd0, 1, 1, 8'h00, 0, 0);
    step(2'd1, 1, 0, 8'h00, 0, 0);
    step(2'd2, 0, 1, 8'h00, 0, 1);
    step(2'd2, 0, 1, 8'h00, 1, 0);
    step(2'd3, 0, 0, 8'h81, 0, 0);
    for (int i = 0; i < W; i++) step(2'd1, 1'b0, 1'b1, 8'h00, 1, 1);
    step(2'd3, 0, 0, 8'h81, 1, 0);
    for (int i = 0; i < W; i++) step(2'd2, 1'b1, 1'b0, 8'h00, 0, 0);

    mid_clear();

    for (int k = 0; k < 400; k++) begin
      step(2'($urandom), 1'($urandom), 1'($urandom), W'($urandom),
           1'($urandom), 1'($urandom));
      if (k % 97 == 50) mid_clear();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule